// File: doc/BRIEF.md
# Process-Tagged Translation Entry Flush Walker

This block clears a retired process out of the address translation caches. On a one-cycle start request carrying an 8-bit process tag, it steps through every entry of both translation buffers: the instruction-side buffer and the data-side buffer, each organised as 4 ways of 16 slots, so 128 entries in all. It reads each entry's upper and lower words through a synchronous read port that returns data one cycle after the request.

For every entry that is valid, not shared between processes, and tagged with the requested process, the block sends out a one-cycle invalidate strobe. The strobe carries that entry's virtual page, placed in address position. When the last entry has been examined, the block signals completion with a one-cycle pulse and returns to idle.

The surrounding logic picks which process to flush and consumes the strobes. The block only walks, compares and reports.

Top module: `pid_flush_walker`

## Requirements
- R1: While reset is asserted and after it is released, with no start request, the read enable, busy, flush strobe, flush address and done outputs are all zero.
- R2: After a start is accepted, the block issues exactly one read per two cycles, for 128 reads in total. The read enable is high in the cycle right after acceptance and in every second cycle after that. The read address `rd_addr_o` is `{buffer[6], way[5:4], slot[3:0]}`: buffer 0 is the instruction side, the slot field advances fastest, and the addresses run from 0 to 127 in order.
- R3: An entry is flushed only when all three hold: lower-word bit 3 (valid) is 1, lower-word bit 4 (shared) is 0, and upper-word bits 7:0 equal the process tag captured at start. Any other entry produces no strobe.
- R4: The flush address is upper-word bits 31:13 (the virtual page) placed at bits 31:13, with bits 12:0 zero. When no strobe is active, the flush address is zero.
- R5: The strobe for the entry read at walk position k is a single-cycle pulse. It is visible 2k+2 clock edges after the edge that accepted the start.
- R6: Done is a single-cycle pulse that appears 256 edges after acceptance. Busy is high from acceptance until that same edge and is low while done is high.
- R7: A start request that arrives while a walk is in progress is ignored. Changes on the process tag input during a walk do not affect which entries are flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a walk |
| pid_i | input | 8 | Process tag to flush, captured with the start |
| rd_en_o | output | 1 | Entry read request |
| rd_addr_o | output | 7 | Entry address {buffer, way, slot} |
| rd_hi_i | input | 32 | Upper entry word, valid the cycle after the request |
| rd_lo_i | input | 32 | Lower entry word, valid the cycle after the request |
| flush_o | output | 1 | Invalidate strobe |
| flush_addr_o | output | 32 | Virtual page address of the flushed entry |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | Walk finished |

## Verification
The bench builds the block with its default geometry: two buffers, four ways, sixteen slots and an 8-bit tag. With these values the full 128-entry walk, including the seam between the instruction and data buffers, is short enough to run in full for every stimulus pattern.

Each pattern fills the entry store from a computed formula. Across the patterns this covers:
- every entry matching;
- no entry matching;
- alternating invalid entries;
- scattered shared entries;
- a lone hit at the first-buffer slot 4;
- a hit on the very last entry, where the final strobe and done coincide.

One run also drives a second start and a changed tag during the walk.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

    typedef enum logic [1:0] {
        PFW_IDLE = 2'd0,
        PFW_READ = 2'd1,
        PFW_CMP  = 2'd2
    } pfw_state_e;

    function automatic int field_w(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/pfw_walk_ctr.sv
module pfw_walk_ctr #(
    parameter int NUM_TLBS = 2,
    parameter int NUM_SETS = 4,
    parameter int NUM_IDX  = 16,
    localparam int TLB_W   = pfw_pkg::field_w(NUM_TLBS),
    localparam int SET_W   = pfw_pkg::field_w(NUM_SETS),
    localparam int IDX_W   = pfw_pkg::field_w(NUM_IDX),
    localparam int ADDR_W  = TLB_W + SET_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    typedef struct packed {
        logic [TLB_W-1:0] tlb;
        logic [SET_W-1:0] set;
        logic [IDX_W-1:0] idx;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic idx_wrap, set_wrap, tlb_wrap;

    always_comb begin
        idx_wrap = (ctr_q.idx == IDX_W'(NUM_IDX - 1));
        set_wrap = (ctr_q.set == SET_W'(NUM_SETS - 1));
        tlb_wrap = (ctr_q.tlb == TLB_W'(NUM_TLBS - 1));
        ctr_d    = ctr_q;
        if (clear_i) begin
            ctr_d = '0;
        end else if (step_i) begin
            if (idx_wrap) begin
                ctr_d.idx = '0;
                if (set_wrap) begin
                    ctr_d.set = '0;
                    ctr_d.tlb = tlb_wrap ? '0 : ctr_q.tlb + 1'b1;
                end else begin
                    ctr_d.set = ctr_q.set + 1'b1;
                end
            end else begin
                ctr_d.idx = ctr_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign addr_o = ctr_q;
    assign last_o = idx_wrap && set_wrap && tlb_wrap;

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (addr_o == '0));

    assert_step_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && !last_o) |=> (addr_o != $past(addr_o)));

endmodule

// File: rtl/pfw_entry_match.sv
module pfw_entry_match #(
    parameter int DATA_W    = 32,
    parameter int PID_W     = 8,
    parameter int PID_LSB   = 0,
    parameter int VPN_LSB   = 13,
    parameter int GLB_BIT   = 4,
    parameter int VLD_BIT   = 3,
    localparam int VPN_W    = DATA_W - VPN_LSB
) (
    input  logic [DATA_W-1:0] hi_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] page_o
);

    logic [PID_W-1:0] ent_pid;
    logic [VPN_W-1:0] ent_vpn;
    logic             ent_glb, ent_vld;
    logic             unused_bits;

    always_comb begin
        ent_pid = hi_i[PID_LSB +: PID_W];
        ent_vpn = hi_i[VPN_LSB +: VPN_W];
        ent_glb = lo_i[GLB_BIT];
        ent_vld = lo_i[VLD_BIT];
        hit_o   = ent_vld && !ent_glb && (ent_pid == pid_i);
        page_o  = {ent_vpn, {VPN_LSB{1'b0}}};
    end

    assign unused_bits = ^{hi_i, lo_i};

endmodule

// File: rtl/pid_flush_walker.sv
module pid_flush_walker #(
    parameter int NUM_TLBS = 2,
    parameter int NUM_SETS = 4,
    parameter int NUM_IDX  = 16,
    parameter int DATA_W   = 32,
    parameter int PID_W    = 8,
    parameter int PID_LSB  = 0,
    parameter int VPN_LSB  = 13,
    parameter int GLB_BIT  = 4,
    parameter int VLD_BIT  = 3,
    localparam int ADDR_W  = pfw_pkg::field_w(NUM_TLBS) + pfw_pkg::field_w(NUM_SETS)
                             + pfw_pkg::field_w(NUM_IDX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_hi_i,
    input  logic [DATA_W-1:0] rd_lo_i,
    output logic              flush_o,
    output logic [DATA_W-1:0] flush_addr_o,
    output logic              busy_o,
    output logic              done_o
);

    import pfw_pkg::*;

    typedef struct packed {
        pfw_state_e        st;
        logic [PID_W-1:0]  pid;
        logic              flush;
        logic [DATA_W-1:0] addr;
        logic              done;
    } walk_t;

    walk_t w_d, w_q;

    logic              ctr_clear, ctr_step, ctr_last;
    logic              ent_hit;
    logic [DATA_W-1:0] ent_page;

    pfw_walk_ctr #(
        .NUM_TLBS(NUM_TLBS),
        .NUM_SETS(NUM_SETS),
        .NUM_IDX (NUM_IDX)
    ) i_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(ctr_clear),
        .step_i (ctr_step),
        .addr_o (rd_addr_o),
        .last_o (ctr_last)
    );

    pfw_entry_match #(
        .DATA_W (DATA_W),
        .PID_W  (PID_W),
        .PID_LSB(PID_LSB),
        .VPN_LSB(VPN_LSB),
        .GLB_BIT(GLB_BIT),
        .VLD_BIT(VLD_BIT)
    ) i_match (
        .hi_i  (rd_hi_i),
        .lo_i  (rd_lo_i),
        .pid_i (w_q.pid),
        .hit_o (ent_hit),
        .page_o(ent_page)
    );

    always_comb begin
        w_d       = w_q;
        w_d.flush = 1'b0;
        w_d.addr  = '0;
        w_d.done  = 1'b0;
        ctr_clear = 1'b0;
        ctr_step  = 1'b0;
        unique case (w_q.st)
            PFW_IDLE: begin
                if (start_i) begin
                    w_d.pid   = pid_i;
                    w_d.st    = PFW_READ;
                    ctr_clear = 1'b1;
                end
            end
            PFW_READ: begin
                w_d.st = PFW_CMP;
            end
            PFW_CMP: begin
                w_d.flush = ent_hit;
                w_d.addr  = ent_hit ? ent_page : '0;
                if (ctr_last) begin
                    w_d.st   = PFW_IDLE;
                    w_d.done = 1'b1;
                end else begin
                    w_d.st   = PFW_READ;
                    ctr_step = 1'b1;
                end
            end
            default: w_d.st = PFW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= PFW_IDLE;
        end else begin
            w_q <= w_d;
        end
    end

    assign rd_en_o      = (w_q.st == PFW_READ);
    assign busy_o       = (w_q.st != PFW_IDLE);
    assign flush_o      = w_q.flush;
    assign flush_addr_o = w_q.addr;
    assign done_o       = w_q.done;

    assert_rd_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o);

    assert_flush_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> ($past(rd_lo_i[VLD_BIT]) && !$past(rd_lo_i[GLB_BIT])
                     && ($past(rd_hi_i[PID_LSB +: PID_W]) == w_q.pid)));

    assert_idle_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_o |-> (flush_addr_o == '0));

    assert_flush_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    assert_flush_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(rd_en_o, 2));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_pid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(w_q.pid));

endmodule

// File: tb/test_pid_flush_walker.sv
`timescale 1ns/1ps
module test_pid_flush_walker;

    localparam int ENTRIES = 128;
    localparam int NCASE   = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  pid_i = '0;
    logic        rd_en_o;
    logic [6:0]  rd_addr_o;
    logic [31:0] rd_hi_i = '0;
    logic [31:0] rd_lo_i = '0;
    logic        flush_o;
    logic [31:0] flush_addr_o;
    logic        busy_o;
    logic        done_o;

    int errors = 0;
    int checks = 0;

    logic [31:0] mem_hi [ENTRIES];
    logic [31:0] mem_lo [ENTRIES];
    logic        exp_hit [ENTRIES];

    // each row: {interfere, mode[1:0], pid[7:0]}
    localparam logic [10:0] CASES [NCASE] = '{
        {1'b0, 2'd0, 8'h5A},
        {1'b0, 2'd1, 8'h5A},
        {1'b0, 2'd2, 8'h5A},
        {1'b1, 2'd3, 8'h5A},
        {1'b0, 2'd0, 8'h33},
        {1'b0, 2'd1, 8'h04},
        {1'b0, 2'd1, 8'h7F}
    };

    always #2.5 clk = ~clk;

    pid_flush_walker i_pid_flush_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pid_i       (pid_i),
        .rd_en_o     (rd_en_o),
        .rd_addr_o   (rd_addr_o),
        .rd_hi_i     (rd_hi_i),
        .rd_lo_i     (rd_lo_i),
        .flush_o     (flush_o),
        .flush_addr_o(flush_addr_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    always @(posedge clk) begin
        if (rd_en_o) begin
            rd_hi_i <= mem_hi[rd_addr_o];
            rd_lo_i <= mem_lo[rd_addr_o];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic fill(input int mode, input logic [7:0] pid);
        for (int e = 0; e < ENTRIES; e++) begin
            logic [18:0] vpn;
            logic [7:0]  tag;
            logic        v, g;
            vpn = 19'(e * 1237 + mode * 91 + 5);
            tag = (mode == 1) ? ((e % 3 == 0) ? 8'h5A : 8'(e)) : 8'h5A;
            v   = (mode == 2) ? e[0] : 1'b1;
            g   = (mode == 3) ? (e % 4 == 1) : 1'b0;
            mem_hi[e]  = {vpn, 5'(e), tag};
            mem_lo[e]  = {19'(e * 77 + 3), 8'(e * 5), g, v, 3'(e)};
            exp_hit[e] = v && !g && (tag == pid);
        end
    endtask

    task automatic run_case(input logic [7:0] pid, input int mode, input bit interfere);
        int n;
        fill(mode, pid);
        @(negedge clk);
        start_i = 1'b1;
        pid_i   = pid;
        @(negedge clk);
        start_i = 1'b0;
        if (interfere) pid_i = ~pid;
        n = 0;
        chk(rd_en_o && rd_addr_o == 7'd0 && busy_o, "R2 first read", {rd_en_o, rd_addr_o}, 8'h80);
        while (n < 260) begin
            @(negedge clk);
            n++;
            if (interfere && n == 10) start_i = 1'b1;
            if (interfere && n == 11) start_i = 1'b0;
            if (n < 256) begin
                if (n % 2 == 0)
                    chk(rd_en_o && rd_addr_o == 7'(n / 2), "R2 read order",
                        {rd_en_o, rd_addr_o}, {1'b1, 7'(n / 2)});
                else
                    chk(!rd_en_o, "R2 read spacing", rd_en_o, 0);
            end
            if (n >= 2 && n <= 256 && n % 2 == 0) begin
                int e;
                e = (n - 2) / 2;
                chk(flush_o == exp_hit[e], interfere ? "R7 flush select" : "R3 flush select",
                    flush_o, exp_hit[e]);
                if (exp_hit[e])
                    chk(flush_addr_o == {mem_hi[e][31:13], 13'd0}, "R4 flush address",
                        flush_addr_o, {mem_hi[e][31:13], 13'd0});
                else
                    chk(flush_addr_o == '0, "R4 idle address", flush_addr_o, 0);
            end else begin
                chk(!flush_o, "R5 strobe timing", flush_o, 0);
            end
            chk(done_o == (n == 256), interfere ? "R7 done unaffected" : "R6 done timing",
                done_o, (n == 256));
            chk(busy_o == (n < 256), "R6 busy window", busy_o, (n < 256));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_en_o && !busy_o && !flush_o && !done_o && flush_addr_o == 0,
            "R1 in reset", {rd_en_o, busy_o, flush_o, done_o}, 0);
        rst_n = 1'b1;
        pid_i = 8'hA5;
        repeat (5) begin
            @(negedge clk);
            chk(!rd_en_o && !busy_o && !flush_o && !done_o && flush_addr_o == 0,
                "R1 idle after reset", {rd_en_o, busy_o, flush_o, done_o}, 0);
        end
        for (int c = 0; c < NCASE; c++) begin
            run_case(CASES[c][7:0], int'(CASES[c][9:8]), CASES[c][10]);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule